// File: doc/BRIEF.md
# Infrared Remote Control Receiver

This block decodes a pulse-width coded infrared remote control signal arriving on a single input. The input is brought into the system clock domain by a two-flop synchronizer and then looked at only on cycles where a slow sampling strobe is high, normally about 32 kHz. Every width and period is measured as a count of those strobes. The line idles high. A frame starts with a low-then-high leader pulse. After the leader comes a train of data bits, and each bit runs from one falling edge to the next. A bit is decoded from the length of that period.

Software programs the leader timing windows, the bit threshold, the maximum bit period and the excess low width through a small word-addressed register bus. A frame ends when the line stays quiet for the maximum bit period, or when it stays low for the excess low width. At that point the decoded bits, up to 72 of them, are copied into three readable buffer words, and the engine goes back to waiting for a leader. Leader detection, every data falling edge and frame completion each set a status flag. The leader and falling-edge flags are set only when their enables are on. Each of the three events can also drive its own one-cycle interrupt pulse. A leaderless mode skips the leader and takes the first pulse as data.

Top module: `ir_rx_top`

## Requirements
- R1: After reset, every register reads zero and all three interrupt outputs are low.
- R2: The input is evaluated only on cycles with `smp_tick` high. Level changes with no strobe produce no event or status change.
- R3: A leader is accepted when two conditions hold: its low width lies within [LDRLO bits 7:0, bits 15:8], and its period up to the next falling edge lies within [LDRPER bits 7:0, bits 15:8]. Widths and periods are counted in strobes. An accepted leader sets status bit 18. A pulse outside either window is dropped.
- R4: A data bit whose falling-to-falling period is at or above BITCFG bits 7:0 decodes as 1, and as 0 otherwise. The first bit goes to BUF0 (address 5) bit 0. BUF0 holds bits 31:0, BUF1 (address 6) holds bits 63:32, and BUF2 (address 7) bits 7:0 hold bits 71:64.
- R5: If no falling edge arrives for BITCFG bits 15:8 strobes, the frame ends. Status bit 16 is set, status bits 6:0 hold the number of bits received, and status bit 21 (done flag) is set.
- R6: If the line stays low for BITCFG bits 23:16 strobes after a falling edge, the frame ends and status bit 17 is set. When both limits are reached on the same strobe, bits 16 and 17 are both set.
- R7: With CTRL bit 1 set, no leader is needed. The first falling edge begins the first data bit, and status bit 18 stays clear.
- R8: CTRL bit 0 enables reception. CTRL bits 2, 3 and 4 gate the one-cycle pulses on `irq_leader`, `irq_fall` and `irq_done`. CTRL bits 2 and 3 also gate status flags 19 and 20. A falling edge event is raised on the edge that opens the first data bit and on every later edge in the frame.
- R9: Reading STATUS (address 4) clears bits 21:18. An event in the same cycle as the read wins, and its flag stays set.
- R10: Bits past the 72nd are dropped. The count stops at 72.
- R11: A completed frame replaces the whole previous buffer contents, whether or not they were read.
- R12: After completion the engine waits for a leader again. Data-sized pulses on their own neither start nor finish a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_tick | input | 1 | Sampling strobe, one clock wide |
| ir_in | input | 1 | Remote control signal, idle high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on STATUS) |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq_leader | output | 1 | Leader accepted pulse |
| irq_fall | output | 1 | Data falling edge pulse |
| irq_done | output | 1 | Frame complete pulse |

## Verification
Two things can land in the same clock: a STATUS read that clears the flags, and the sampling strobe that completes a frame. The bench counts strobes from the final falling edge and holds the line low, so it knows the exact strobe on which the excess-low limit is reached. It raises the STATUS read in that same cycle. The value returned must be the pre-completion word. A second read must then show the done flag set, along with both end-cause bits, because the excess-low limit and the maximum bit period are programmed equal. A third read confirms the flag was cleared only by that later read.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_LLOW  = 2'd1,
        ST_LHIGH = 2'd2,
        ST_DATA  = 2'd3
    } rx_state_e;

    localparam int A_CTRL  = 0;
    localparam int A_LDRLO = 1;
    localparam int A_LDRPR = 2;
    localparam int A_BITCF = 3;
    localparam int A_STAT  = 4;
    localparam int A_BUF0  = 5;

    localparam int C_EN   = 0;
    localparam int C_NOLD = 1;
    localparam int C_LIEN = 2;
    localparam int C_FIEN = 3;
    localparam int C_DIEN = 4;
    localparam int C_W    = 5;

    localparam int S_CYC  = 16;
    localparam int S_LOW  = 17;
    localparam int S_LDET = 18;
    localparam int S_FLDR = 19;
    localparam int S_FFAL = 20;
    localparam int S_FDON = 21;
endpackage

// File: rtl/ir_rx_sampler.sv
module ir_rx_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ir_in,
    output logic lvl,
    output logic fall,
    output logic rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d    = smp_q;
        smp_d.s1 = ir_in;
        smp_d.s2 = smp_q.s1;
        if (tick) smp_d.prev = smp_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '1;
        else        smp_q <= smp_d;
    end

    assign lvl  = smp_q.s2;
    assign fall = tick &  smp_q.prev & ~smp_q.s2;
    assign rise = tick & ~smp_q.prev &  smp_q.s2;
endmodule

// File: rtl/ir_rx_engine.sv
module ir_rx_engine
    import ir_rx_pkg::*;
#(
    parameter int CW    = 8,
    parameter int NBITS = 72,
    parameter int BCW   = $clog2(NBITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             leaderless,
    input  logic             tick,
    input  logic             lvl,
    input  logic             fall,
    input  logic             rise,
    input  logic [CW-1:0]    lo_min,
    input  logic [CW-1:0]    lo_max,
    input  logic [CW-1:0]    per_min,
    input  logic [CW-1:0]    per_max,
    input  logic [CW-1:0]    thr,
    input  logic [CW-1:0]    max_cyc,
    input  logic [CW-1:0]    ex_low,
    output logic             ev_leader,
    output logic             ev_fall,
    output logic             ev_done,
    output logic             by_cyc,
    output logic             by_low,
    output logic [BCW-1:0]   bitcnt,
    output logic [NBITS-1:0] data,
    output logic             busy
);
    typedef struct packed {
        rx_state_e        st;
        logic [CW-1:0]    cnt;
        logic [BCW-1:0]   nb;
        logic [NBITS-1:0] sh;
    } eng_t;

    eng_t eng_d, eng_q;
    logic [CW-1:0] k;

    always_comb begin
        eng_d     = eng_q;
        ev_leader = 1'b0;
        ev_fall   = 1'b0;
        ev_done   = 1'b0;
        by_cyc    = 1'b0;
        by_low    = 1'b0;
        k = (&eng_q.cnt) ? eng_q.cnt : eng_q.cnt + 1'b1;
        if (!enable) begin
            eng_d.st  = ST_WAIT;
            eng_d.cnt = '0;
        end else if (tick) begin
            eng_d.cnt = k;
            case (eng_q.st)
                ST_WAIT: begin
                    if (fall) begin
                        eng_d.cnt = '0;
                        eng_d.nb  = '0;
                        eng_d.sh  = '0;
                        if (leaderless) begin
                            eng_d.st = ST_DATA;
                            ev_fall  = 1'b1;
                        end else begin
                            eng_d.st = ST_LLOW;
                        end
                    end
                end
                ST_LLOW: begin
                    if (rise) begin
                        eng_d.st = (k >= lo_min && k <= lo_max) ? ST_LHIGH : ST_WAIT;
                    end else if (k > lo_max) begin
                        eng_d.st = ST_WAIT;
                    end
                end
                ST_LHIGH: begin
                    if (fall) begin
                        eng_d.cnt = '0;
                        if (k >= per_min && k <= per_max) begin
                            eng_d.st  = ST_DATA;
                            ev_leader = 1'b1;
                            ev_fall   = 1'b1;
                        end else begin
                            eng_d.st = ST_LLOW;
                        end
                    end else if (k > per_max) begin
                        eng_d.st = ST_WAIT;
                    end
                end
                ST_DATA: begin
                    if (fall) begin
                        eng_d.cnt = '0;
                        ev_fall   = 1'b1;
                        if (eng_q.nb < BCW'(NBITS)) begin
                            eng_d.sh[eng_q.nb] = (k >= thr);
                            eng_d.nb = eng_q.nb + 1'b1;
                        end
                    end else begin
                        by_low = !lvl && (k >= ex_low);
                        by_cyc = (k >= max_cyc);
                        if (by_low || by_cyc) begin
                            ev_done  = 1'b1;
                            eng_d.st = ST_WAIT;
                        end
                    end
                end
                default: eng_d.st = ST_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign bitcnt = eng_q.nb;
    assign data   = eng_q.sh;
    assign busy   = (eng_q.st != ST_WAIT);
endmodule

// File: rtl/ir_rx_regs.sv
module ir_rx_regs
    import ir_rx_pkg::*;
#(
    parameter int CW    = 8,
    parameter int NBITS = 72,
    parameter int AW    = 4,
    parameter int DW    = 32,
    parameter int BCW   = $clog2(NBITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic             ev_leader,
    input  logic             ev_fall,
    input  logic             ev_done,
    input  logic             by_cyc,
    input  logic             by_low,
    input  logic [BCW-1:0]   bitcnt,
    input  logic [NBITS-1:0] data,
    output logic [C_W-1:0]   ctrl,
    output logic [CW-1:0]    lo_min,
    output logic [CW-1:0]    lo_max,
    output logic [CW-1:0]    per_min,
    output logic [CW-1:0]    per_max,
    output logic [CW-1:0]    thr,
    output logic [CW-1:0]    max_cyc,
    output logic [CW-1:0]    ex_low,
    output logic             done_flag,
    output logic             irq_leader,
    output logic             irq_fall,
    output logic             irq_done
);
    localparam int NW = (NBITS + DW - 1) / DW;

    typedef struct packed {
        logic [C_W-1:0]   ctrl;
        logic [CW-1:0]    lo_min, lo_max, per_min, per_max;
        logic [CW-1:0]    thr, max_cyc, ex_low;
        logic [BCW-1:0]   cnt;
        logic             cyc, low, ldet, f_ldr, f_fall, f_done;
        logic [NBITS-1:0] rxbuf;
        logic             i_ldr, i_fall, i_done;
    } reg_t;

    reg_t r_d, r_q;
    logic [NW*DW-1:0] bufpad;

    always_comb begin
        r_d = r_q;
        r_d.i_ldr  = ev_leader & r_q.ctrl[C_LIEN];
        r_d.i_fall = ev_fall   & r_q.ctrl[C_FIEN];
        r_d.i_done = ev_done   & r_q.ctrl[C_DIEN];
        if (bus_wr) begin
            if (bus_addr == AW'(A_CTRL))  r_d.ctrl = bus_wdata[C_W-1:0];
            if (bus_addr == AW'(A_LDRLO)) {r_d.lo_max, r_d.lo_min} = bus_wdata[2*CW-1:0];
            if (bus_addr == AW'(A_LDRPR)) {r_d.per_max, r_d.per_min} = bus_wdata[2*CW-1:0];
            if (bus_addr == AW'(A_BITCF)) {r_d.ex_low, r_d.max_cyc, r_d.thr} = bus_wdata[3*CW-1:0];
        end
        if (bus_rd && bus_addr == AW'(A_STAT)) begin
            r_d.ldet   = 1'b0;
            r_d.f_ldr  = 1'b0;
            r_d.f_fall = 1'b0;
            r_d.f_done = 1'b0;
        end
        if (ev_leader) begin
            r_d.ldet = 1'b1;
            if (r_q.ctrl[C_LIEN]) r_d.f_ldr = 1'b1;
        end
        if (ev_fall && r_q.ctrl[C_FIEN]) r_d.f_fall = 1'b1;
        if (ev_done) begin
            r_d.f_done = 1'b1;
            r_d.cnt    = bitcnt;
            r_d.cyc    = by_cyc;
            r_d.low    = by_low;
            r_d.rxbuf  = data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bufpad = '0;
        bufpad[NBITS-1:0] = r_q.rxbuf;
        bus_rdata = '0;
        if (bus_addr == AW'(A_CTRL))  bus_rdata[C_W-1:0] = r_q.ctrl;
        if (bus_addr == AW'(A_LDRLO)) bus_rdata[2*CW-1:0] = {r_q.lo_max, r_q.lo_min};
        if (bus_addr == AW'(A_LDRPR)) bus_rdata[2*CW-1:0] = {r_q.per_max, r_q.per_min};
        if (bus_addr == AW'(A_BITCF)) bus_rdata[3*CW-1:0] = {r_q.ex_low, r_q.max_cyc, r_q.thr};
        if (bus_addr == AW'(A_STAT)) begin
            bus_rdata[BCW-1:0] = r_q.cnt;
            bus_rdata[S_CYC]   = r_q.cyc;
            bus_rdata[S_LOW]   = r_q.low;
            bus_rdata[S_LDET]  = r_q.ldet;
            bus_rdata[S_FLDR]  = r_q.f_ldr;
            bus_rdata[S_FFAL]  = r_q.f_fall;
            bus_rdata[S_FDON]  = r_q.f_done;
        end
        for (int i = 0; i < NW; i++) begin
            if (bus_addr == AW'(A_BUF0 + i)) bus_rdata = bufpad[i*DW +: DW];
        end
    end

    assign ctrl       = r_q.ctrl;
    assign lo_min     = r_q.lo_min;
    assign lo_max     = r_q.lo_max;
    assign per_min    = r_q.per_min;
    assign per_max    = r_q.per_max;
    assign thr        = r_q.thr;
    assign max_cyc    = r_q.max_cyc;
    assign ex_low     = r_q.ex_low;
    assign done_flag  = r_q.f_done;
    assign irq_leader = r_q.i_ldr;
    assign irq_fall   = r_q.i_fall;
    assign irq_done   = r_q.i_done;
endmodule

// File: rtl/ir_rx_top.sv
module ir_rx_top
    import ir_rx_pkg::*;
#(
    parameter int CW    = 8,
    parameter int NBITS = 72,
    parameter int AW    = 4,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_tick,
    input  logic          ir_in,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_leader,
    output logic          irq_fall,
    output logic          irq_done
);
    localparam int BCW = $clog2(NBITS + 1);

    logic lvl, fall, rise;
    logic ev_leader, ev_fall, ev_done, by_cyc, by_low, busy, done_flag, fall_en;
    logic [BCW-1:0]   bitcnt;
    logic [NBITS-1:0] data;
    logic [C_W-1:0]   ctrl;
    logic [CW-1:0]    lo_min, lo_max, per_min, per_max, thr, max_cyc, ex_low;

    assign fall_en = ctrl[C_FIEN];

    ir_rx_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .tick(smp_tick), .ir_in(ir_in),
        .lvl(lvl), .fall(fall), .rise(rise)
    );

    ir_rx_engine #(.CW(CW), .NBITS(NBITS), .BCW(BCW)) u_eng (
        .clk(clk), .rst_n(rst_n), .enable(ctrl[C_EN]), .leaderless(ctrl[C_NOLD]),
        .tick(smp_tick), .lvl(lvl), .fall(fall), .rise(rise),
        .lo_min(lo_min), .lo_max(lo_max), .per_min(per_min), .per_max(per_max),
        .thr(thr), .max_cyc(max_cyc), .ex_low(ex_low),
        .ev_leader(ev_leader), .ev_fall(ev_fall), .ev_done(ev_done),
        .by_cyc(by_cyc), .by_low(by_low), .bitcnt(bitcnt), .data(data), .busy(busy)
    );

    ir_rx_regs #(.CW(CW), .NBITS(NBITS), .AW(AW), .DW(DW), .BCW(BCW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_leader(ev_leader), .ev_fall(ev_fall), .ev_done(ev_done),
        .by_cyc(by_cyc), .by_low(by_low), .bitcnt(bitcnt), .data(data),
        .ctrl(ctrl), .lo_min(lo_min), .lo_max(lo_max), .per_min(per_min),
        .per_max(per_max), .thr(thr), .max_cyc(max_cyc), .ex_low(ex_low),
        .done_flag(done_flag), .irq_leader(irq_leader), .irq_fall(irq_fall),
        .irq_done(irq_done)
    );
endmodule

// File: rtl/ir_rx_chk.sv
module ir_rx_chk #(
    parameter int NBITS = 72,
    parameter int BCW   = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           smp_tick,
    input logic           ev_leader,
    input logic           ev_fall,
    input logic           ev_done,
    input logic           busy,
    input logic [BCW-1:0] bitcnt,
    input logic           fall_en,
    input logic           irq_fall,
    input logic           irq_done,
    input logic           done_flag
);
    AST_EVT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_leader || ev_fall || ev_done) |-> smp_tick); // R2
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= BCW'(NBITS)); // R10
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> !busy); // R12
    AST_FALL_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fall |-> $past(fall_en)); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done); // R5
    AST_DONE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> done_flag); // R9
endmodule

bind ir_rx_top ir_rx_chk #(.NBITS(NBITS), .BCW(BCW)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .ev_leader(ev_leader),
    .ev_fall(ev_fall), .ev_done(ev_done), .busy(busy), .bitcnt(bitcnt),
    .fall_en(fall_en), .irq_fall(irq_fall), .irq_done(irq_done),
    .done_flag(done_flag)
);

// File: tb/sim_ir_rx_top.sv
`timescale 1ns/1ps
module sim_ir_rx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_tick = 1'b0;
    logic        ir_in = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_leader, irq_fall, irq_done;

    int total = 0;
    int bad = 0;
    int n_ldr = 0, n_fall = 0, n_done = 0;
    int one_h = 6, zero_h = 2;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ir_rx_top u0 (
        .clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .ir_in(ir_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_leader(irq_leader), .irq_fall(irq_fall), .irq_done(irq_done)
    );

    always @(negedge clk) begin
        if (irq_leader) n_ldr++;
        if (irq_fall)   n_fall++;
        if (irq_done)   n_done++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 4'(a);
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); smp_tick = 1'b1;
        @(negedge clk); smp_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic set_ir(input logic v);
        @(negedge clk); ir_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse(input int lo, input int hi);
        set_ir(1'b0); ticks(lo);
        set_ir(1'b1); ticks(hi);
    endtask

    task automatic clr_irq();
        n_ldr = 0; n_fall = 0; n_done = 0;
    endtask

    task automatic send(input bit ldr, input int n, input logic [79:0] pat, input bit low_end);
        if (ldr) pulse(10, 6);
        for (int i = 0; i < n; i++) pulse(2, pat[i] ? one_h : zero_h);
        if (low_end) begin
            set_ir(1'b0); ticks(10); set_ir(1'b1); ticks(2);
        end else begin
            pulse(2, 2); ticks(16);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(a, v);
            chk($sformatf("R1 reg %0d after reset", a), v, 32'h0);
        end
        chk("R1 irq lines after reset", {29'h0, irq_leader, irq_fall, irq_done}, 32'h0);
    endtask

    task automatic t_no_tick();
        logic [31:0] v;
        clr_irq();
        @(negedge clk); ir_in = 1'b0;
        repeat (30) @(negedge clk);
        ir_in = 1'b1;
        repeat (30) @(negedge clk);
        ticks(5);
        rd(4, v);
        chk("R2 no strobe no status", v, 32'h0);
        chk("R2 no strobe no fall irq", n_fall, 0);
    endtask

    task automatic t_bad_leader();
        logic [31:0] v;
        clr_irq();
        pulse(4, 6);
        pulse(10, 20);
        ticks(5);
        rd(4, v);
        chk("R3 out-of-window leaders dropped", v, 32'h0);
        chk("R3 no leader irq", n_ldr, 0);
    endtask

    task automatic t_frame_cycle_end();
        logic [31:0] v;
        clr_irq();
        send(1'b1, 12, 80'h9A7, 1'b0);
        rd(4, v);
        chk("R5 status after max-cycle end", v, 32'd12 | (1 << 16) | (1 << 18) | (1 << 19) | (1 << 20) | (1 << 21));
        rd(5, v);
        chk("R4 BUF0 decoded bits", v, 32'h9A7);
        chk("R8 leader irq count", n_ldr, 1);
        chk("R8 fall irq count", n_fall, 13);
        chk("R8 done irq count", n_done, 1);
        rd(4, v);
        chk("R9 flags cleared by read", v, 32'd12 | (1 << 16));
    endtask

    task automatic t_no_restart();
        logic [31:0] v;
        clr_irq();
        pulse(2, 2);
        pulse(2, 6);
        ticks(20);
        rd(4, v);
        chk("R12 data pulses alone start nothing", v, 32'd12 | (1 << 16));
        chk("R12 no fall irq while waiting", n_fall, 0);
    endtask

    task automatic t_low_end();
        logic [31:0] v;
        clr_irq();
        wr(0, 32'h01);
        send(1'b1, 5, 80'h13, 1'b1);
        rd(4, v);
        chk("R6 status after excess-low end", v, 32'd5 | (1 << 17) | (1 << 18) | (1 << 21));
        rd(5, v);
        chk("R11 BUF0 overwritten", v, 32'h13);
        chk("R8 irqs gated off", n_ldr + n_fall + n_done, 0);
    endtask

    task automatic t_leaderless();
        logic [31:0] v;
        rd(4, v);
        clr_irq();
        wr(0, 32'h1B);
        send(1'b0, 8, 80'hA5, 1'b0);
        rd(4, v);
        chk("R7 leaderless status", v, 32'd8 | (1 << 16) | (1 << 20) | (1 << 21));
        rd(5, v);
        chk("R7 leaderless data", v, 32'hA5);
        chk("R7 leaderless fall irq count", n_fall, 9);
        chk("R7 leaderless leader irq", n_ldr, 0);
    endtask

    task automatic t_long();
        logic [31:0] v;
        logic [79:0] pat;
        logic [95:0] exp;
        pat = '0;
        for (int i = 0; i < 75; i++) pat[i] = ((i % 3) == 0) ^ ((i % 7) == 2);
        exp = '0;
        exp[71:0] = pat[71:0];
        rd(4, v);
        clr_irq();
        wr(0, 32'h09);
        send(1'b1, 75, pat, 1'b0);
        rd(4, v);
        chk("R10 count stops at 72", v, 32'd72 | (1 << 16) | (1 << 18) | (1 << 20) | (1 << 21));
        rd(5, v); chk("R4 BUF0 long frame", v, exp[31:0]);
        rd(6, v); chk("R4 BUF1 long frame", v, exp[63:32]);
        rd(7, v); chk("R10 BUF2 holds bits 71:64 only", v, exp[95:64]);
        chk("R8 fall irq count long frame", n_fall, 76);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        wr(0, 32'h01);
        wr(3, 32'h060606);
        rd(4, v);
        one_h = 4; zero_h = 2;
        pulse(10, 6);
        for (int i = 0; i < 4; i++) pulse(2, ((4'hB >> i) & 1) ? one_h : zero_h);
        set_ir(1'b0);
        ticks(6);
        @(negedge clk);
        smp_tick = 1'b1; bus_rd = 1'b1; bus_addr = 4'd4;
        #1 v = bus_rdata;
        @(negedge clk);
        smp_tick = 1'b0; bus_rd = 1'b0;
        chk("R9 read in completion cycle returns old word", v, 32'd72 | (1 << 16) | (1 << 18));
        set_ir(1'b1);
        rd(4, v);
        chk("R9 done flag survives same-cycle read, R6 both causes", v, 32'd4 | (1 << 16) | (1 << 17) | (1 << 21));
        rd(4, v);
        chk("R9 flag cleared by later read", v, 32'd4 | (1 << 16) | (1 << 17));
        rd(5, v);
        chk("R4 threshold equal period decodes as 1", v, 32'hB);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        wr(0, 32'h1D);
        wr(1, 32'h0C08);
        wr(2, 32'h1410);
        wr(3, 32'h060C06);
        t_no_tick();
        t_bad_leader();
        t_frame_cycle_end();
        t_no_restart();
        t_low_end();
        t_leaderless();
        t_long();
        t_same_cycle();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule